// File: doc/BRIEF.md
# Merged Multi-Page-Size Translation Buffer

This block is a set-associative address translation cache that keeps 4 KB and 2 MB page translations in one common pool of entries. No way or set is reserved for one page size. The virtual address space is cut into non-overlapping regions, and each region uses one page size only. The two most significant virtual address bits name the region. That gives the page size before the array is indexed, so the set index and the tag can be taken from the right bit positions for that size.

Commands come in one per cycle: lookup, fill, invalidate one page, or flush everything. A lookup returns hit, miss or fault, together with the translated physical address, one cycle later. Page table walking and region management belong to the surrounding logic. Replacement within a set uses a binary-tree pseudo-LRU that serves entries of both sizes alike.

Top module: `mtlb_merged`

## Requirements
- R1: After synchronous reset every entry is invalid and all response outputs are 0. A lookup that follows reset misses.
- R2: The region is `cmd_va[47:46]`. Region 0 maps 4 KB pages and region 1 maps 2 MB pages. Regions 2 and 3 map nothing. A lookup there gives `rsp_fault`=1, `rsp_hit`=0 and `rsp_pa`=0.
- R3: `rsp_valid` is 1 in exactly the cycle after a lookup command (`cmd_op`=0) and is 0 after any other cycle.
- R4: A 4 KB hit returns `rsp_pa` = {stored frame, `cmd_va[11:0]`}.
- R5: A 2 MB hit returns `rsp_pa` = {stored frame[27:9], `cmd_va[20:0]`}. The low 9 frame bits are ignored.
- R6: The set index is the 4 bits just above the page offset: `va[15:12]` for 4 KB and `va[24:21]` for 2 MB. The tag is every bit above the index. A hit needs a valid entry whose tag and size both match.
- R7: Entries of both sizes share the ways of a set. A set can hold any mix of them at once.
- R8: A fill (`cmd_op`=1, frame on `cmd_pfn`) of a page that is already present rewrites that entry in place. Otherwise it goes to the lowest invalid way, or if the set is full, to the tree pseudo-LRU victim. Lookup hits and fills mark their way as most recently used.
- R9: Invalidate-page (`cmd_op`=2) removes only the entry that matches the page of `cmd_va`, with the size taken from its region. Every other entry stays.
- R10: Flush (`cmd_op`=3) invalidates every entry at once.
- R11: A fill or invalidate-page whose address lies in a fault region changes no entry and no replacement state.
- R12: A miss gives `rsp_valid`=1, `rsp_hit`=0, `rsp_fault`=0 and `rsp_pa`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 lookup, 1 fill, 2 invalidate page, 3 flush |
| cmd_va | input | 48 | Virtual address |
| cmd_pfn | input | 28 | Physical frame in 4 KB units, used by fill |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | Address in an unmapped region |
| rsp_pa | output | 40 | Translated physical address |

## Verification
The hardest case to reach from the ports is a full set whose entries mix both page sizes. In that set the pseudo-LRU victim depends on the order of earlier hits and fills. The stimulus fills one set with 4 KB and 2 MB pages, touches chosen ways, and then forces more fills so that evictions happen. A behavioural model compares every response each cycle. A randomized phase then aims all four regions at a few sets and repeats addresses often, so that in-place refills, invalidations of absent pages and fault-region fills into full sets all occur.

// File: rtl/mtlb_pkg.sv
package mtlb_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP   = 2'd0,
    OP_FILL     = 2'd1,
    OP_INV_PAGE = 2'd2,
    OP_FLUSH    = 2'd3
  } tlb_op_e;

  // size code stored with each entry
  localparam logic SZ_SMALL = 1'b0;  // 4 KB
  localparam logic SZ_LARGE = 1'b1;  // 2 MB

  localparam int OFF_SMALL = 12;
  localparam int OFF_LARGE = 21;
endpackage

// File: rtl/mtlb_addr_dec.sv
module mtlb_addr_dec
  import mtlb_pkg::*;
#(
  parameter int VA_W  = 48,
  parameter int REG_W = 2,
  parameter int IDX_W = 4,
  parameter int TAG_W = 32
) (
  input  logic [VA_W-1:0]  va,
  output logic             fault,
  output logic             sz,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag,
  output logic [VA_W-1:0]  off_mask
);
  logic [REG_W-1:0] region;
  int               shamt;

  always_comb begin
    region = va[VA_W-1 -: REG_W];
    fault  = 1'b0;
    sz     = SZ_SMALL;
    if (region == REG_W'(0)) begin
      sz = SZ_SMALL;
    end else if (region == REG_W'(1)) begin
      sz = SZ_LARGE;
    end else begin
      fault = 1'b1;
    end
    shamt    = (sz == SZ_LARGE) ? OFF_LARGE : OFF_SMALL;
    idx      = IDX_W'(va >> shamt);
    tag      = TAG_W'(va >> (shamt + IDX_W));
    off_mask = VA_W'((64'd1 << shamt) - 64'd1);
  end
endmodule

// File: rtl/mtlb_way_match.sv
module mtlb_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 32,
  localparam int WW   = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            vld,
  input  logic [WAYS-1:0]            szs,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           q_tag,
  input  logic                       q_sz,
  output logic                       hit,
  output logic [WW-1:0]              hit_way
);
  logic [WAYS-1:0] hv;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hv[w] = vld[w] && (szs[w] == q_sz) && (tags[w] == q_tag);
  end

  always_comb begin
    hit     = |hv;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hv[w]) hit_way = WW'(w);
    end
  end
endmodule

// File: rtl/mtlb_plru.sv
module mtlb_plru #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WW    = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_set,
  output logic [WW-1:0]    victim,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_set,
  input  logic [WW-1:0]    upd_way
);
  logic [WAYS-2:0] tree [SETS];
  logic [WAYS-2:0] cur;
  logic [WAYS-2:0] nxt;

  // walk the tree: each node bit names the half holding the victim
  always_comb begin
    int node;
    logic b;
    cur    = tree[rd_set];
    victim = '0;
    node   = 1;
    for (int l = WW - 1; l >= 0; l--) begin
      b         = cur[node-1];
      victim[l] = b;
      node      = 2 * node + (b ? 1 : 0);
    end
  end

  // point every node on the used path away from it
  always_comb begin
    int node;
    logic b;
    nxt  = tree[upd_set];
    node = 1;
    for (int l = WW - 1; l >= 0; l--) begin
      b           = upd_way[l];
      nxt[node-1] = ~b;
      node        = 2 * node + (b ? 1 : 0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree[s] <= '0;
    end else if (upd_en) begin
      tree[upd_set] <= nxt;
    end
  end
endmodule

// File: rtl/mtlb_merged.sv
module mtlb_merged
  import mtlb_pkg::*;
#(
  parameter int VA_W  = 48,
  parameter int PA_W  = 40,
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int REG_W = 2,
  localparam int PFN_W = PA_W - OFF_SMALL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [VA_W-1:0]  cmd_va,
  input  logic [PFN_W-1:0] cmd_pfn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_pa
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WW    = $clog2(WAYS);
  localparam int TAG_W = VA_W - OFF_SMALL - IDX_W;

  // entry storage: valid bits in flops, payload in plain arrays
  logic [WAYS-1:0]            e_valid [SETS];
  logic [WAYS-1:0]            e_sz    [SETS];
  logic [WAYS-1:0][TAG_W-1:0] e_tag   [SETS];
  logic [WAYS-1:0][PFN_W-1:0] e_pfn   [SETS];

  logic             q_fault, q_sz;
  logic [IDX_W-1:0] q_idx;
  logic [TAG_W-1:0] q_tag;
  logic [VA_W-1:0]  q_mask;

  mtlb_addr_dec #(
    .VA_W(VA_W), .REG_W(REG_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_dec (
    .va(cmd_va), .fault(q_fault), .sz(q_sz), .idx(q_idx),
    .tag(q_tag), .off_mask(q_mask)
  );

  logic          hit;
  logic [WW-1:0] hit_way;

  mtlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .vld(e_valid[q_idx]), .szs(e_sz[q_idx]), .tags(e_tag[q_idx]),
    .q_tag(q_tag), .q_sz(q_sz), .hit(hit), .hit_way(hit_way)
  );

  logic do_lookup, do_fill, do_inv, do_flush;
  always_comb begin
    do_lookup = cmd_valid && (cmd_op == OP_LOOKUP);
    do_fill   = cmd_valid && (cmd_op == OP_FILL) && !q_fault;
    do_inv    = cmd_valid && (cmd_op == OP_INV_PAGE) && !q_fault && hit;
    do_flush  = cmd_valid && (cmd_op == OP_FLUSH);
  end

  logic          has_free;
  logic [WW-1:0] free_way;
  logic [WW-1:0] victim;
  logic [WW-1:0] fill_way;

  always_comb begin
    has_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!e_valid[q_idx][w]) begin
        has_free = 1'b1;
        free_way = WW'(w);
      end
    end
    if (hit)           fill_way = hit_way;
    else if (has_free) fill_way = free_way;
    else               fill_way = victim;
  end

  logic          lk_hit;
  logic          upd_en;
  logic [WW-1:0] upd_way;
  assign lk_hit  = do_lookup && !q_fault && hit;
  assign upd_en  = lk_hit || do_fill;
  assign upd_way = do_fill ? fill_way : hit_way;

  mtlb_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk(clk), .rst(rst), .rd_set(q_idx), .victim(victim),
    .upd_en(upd_en), .upd_set(q_idx), .upd_way(upd_way)
  );

  // physical address: frame above the size's offset, VA offset below it
  logic [PA_W-1:0] pa_base, pa_mask, pa_va, pa_next;
  always_comb begin
    pa_base = {e_pfn[q_idx][hit_way], {OFF_SMALL{1'b0}}};
    pa_mask = PA_W'(q_mask);
    pa_va   = PA_W'(cmd_va);
    pa_next = (pa_base & ~pa_mask) | (pa_va & pa_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= do_lookup;
      rsp_hit   <= lk_hit;
      rsp_fault <= do_lookup && q_fault;
      rsp_pa    <= lk_hit ? pa_next : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || do_flush) begin
      for (int s = 0; s < SETS; s++) e_valid[s] <= '0;
    end else if (do_fill) begin
      e_valid[q_idx][fill_way] <= 1'b1;
    end else if (do_inv) begin
      e_valid[q_idx][hit_way] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      e_sz[q_idx][fill_way]  <= q_sz;
      e_tag[q_idx][fill_way] <= q_tag;
      e_pfn[q_idx][fill_way] <= cmd_pfn;
    end
  end
endmodule

// File: rtl/mtlb_merged_chk.sv
module mtlb_merged_chk #(
  parameter int VA_W  = 48,
  parameter int PA_W  = 40,
  parameter int REG_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_valid,
  input logic [1:0]      cmd_op,
  input logic [VA_W-1:0] cmd_va,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_fault,
  input logic [PA_W-1:0] rsp_pa
);
  logic lookup, flush, bad_region;
  assign lookup     = cmd_valid && (cmd_op == 2'd0);
  assign flush      = cmd_valid && (cmd_op == 2'd3);
  assign bad_region = cmd_va[VA_W-1 -: REG_W] > REG_W'(1);

  a_r3_rsp_follows_lookup: assert property (@(posedge clk) disable iff (rst)
    lookup |=> rsp_valid);
  a_r3_no_stray_rsp: assert property (@(posedge clk) disable iff (rst)
    !lookup |=> !rsp_valid);
  a_r2_fault_region: assert property (@(posedge clk) disable iff (rst)
    (lookup && bad_region) |=> (rsp_fault && !rsp_hit && rsp_pa == '0));
  a_r2_mapped_no_fault: assert property (@(posedge clk) disable iff (rst)
    (lookup && !bad_region) |=> !rsp_fault);
  a_r12_miss_pa_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_pa == '0));
  a_r4_offset_kept: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_pa[11:0] == $past(cmd_va[11:0])));
  a_r10_flush_then_miss: assert property (@(posedge clk) disable iff (rst)
    ($past(flush) && lookup) |=> !rsp_hit);
  a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_hit, rsp_fault}));
endmodule

bind mtlb_merged mtlb_merged_chk #(.VA_W(VA_W), .PA_W(PA_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_va(cmd_va),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa)
);

// File: tb/mtlb_merged_bench.sv
module mtlb_merged_bench;
  localparam int NS = 16;
  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [47:0] cmd_va = '0;
  logic [27:0] cmd_pfn = '0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [39:0] rsp_pa;

  always #10 clk = ~clk;

  mtlb_merged u_mtlb_merged (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_va(cmd_va), .cmd_pfn(cmd_pfn), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa)
  );

  int vectors = 0;
  int errors  = 0;

  // behavioural reference: entries keyed by full virtual page number
  bit              m_v   [NS][NW];
  int              m_sz  [NS][NW];
  longint unsigned m_vpn [NS][NW];
  longint unsigned m_pfn [NS][NW];
  int              m_tree[NS][NW-1];

  bit              e_valid, e_hit, e_fault;
  longint unsigned e_pa;

  function automatic int pick_victim(int s);
    int node = 1, w = 0, b;
    for (int l = 0; l < 2; l++) begin
      b = m_tree[s][node-1];
      w = w * 2 + b;
      node = 2 * node + b;
    end
    return w;
  endfunction

  function automatic void touch(int s, int w);
    int node = 1, b;
    for (int l = 0; l < 2; l++) begin
      b = (w >> (1 - l)) & 1;
      m_tree[s][node-1] = 1 - b;
      node = 2 * node + b;
    end
  endfunction

  function automatic void model_step(bit v, int op, longint unsigned va, longint unsigned pfn);
    int rg, sz, off, s, hw, w;
    longint unsigned vpn, mask;
    e_valid = 0; e_hit = 0; e_fault = 0; e_pa = 0;
    if (!v) return;
    rg  = int'(va >> 46);
    sz  = (rg == 1) ? 1 : 0;
    off = sz ? 21 : 12;
    vpn = va >> off;
    s   = int'(vpn & 15);
    hw  = -1;
    if (rg < 2)
      for (int i = 0; i < NW; i++)
        if (m_v[s][i] && m_sz[s][i] == sz && m_vpn[s][i] == vpn && hw < 0) hw = i;
    mask = (64'd1 << off) - 1;
    case (op)
      0: begin
        e_valid = 1;
        if (rg >= 2) e_fault = 1;
        else if (hw >= 0) begin
          e_hit = 1;
          e_pa  = (((m_pfn[s][hw] << 12) & ~mask) | (va & mask)) & ((64'd1 << 40) - 1);
          touch(s, hw);
        end
      end
      1: if (rg < 2) begin
        w = hw;
        if (w < 0)
          for (int i = NW - 1; i >= 0; i--) if (!m_v[s][i]) w = i;
        if (w < 0) w = pick_victim(s);
        m_v[s][w] = 1; m_sz[s][w] = sz; m_vpn[s][w] = vpn; m_pfn[s][w] = pfn;
        touch(s, w);
      end
      2: if (rg < 2 && hw >= 0) m_v[s][hw] = 0;
      default: for (int i = 0; i < NS; i++) for (int j = 0; j < NW; j++) m_v[i][j] = 0;
    endcase
  endfunction

  task automatic compare(string rq);
    vectors++;
    if (rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_fault !== e_fault ||
        rsp_pa !== 40'(e_pa)) begin
      errors++;
      $display("FAIL %s: got v=%0b h=%0b f=%0b pa=%h, expected v=%0b h=%0b f=%0b pa=%h",
               rq, rsp_valid, rsp_hit, rsp_fault, rsp_pa, e_valid, e_hit, e_fault, 40'(e_pa));
    end
  endtask

  // drive at a falling edge, the block registers at the rising edge,
  // compare at the next falling edge
  task automatic apply(bit v, int op, longint unsigned va, longint unsigned pfn, string rq);
    cmd_valid = v; cmd_op = 2'(op); cmd_va = 48'(va); cmd_pfn = 28'(pfn);
    model_step(v, op, va, pfn);
    @(negedge clk);
    compare(rq);
  endtask

  function automatic longint unsigned mk(int rg, int sz, longint unsigned tag, int set, longint unsigned low);
    int off = sz ? 21 : 12;
    return (longint'(rg) << 46) | (tag << (off + 4)) | (longint'(set) << off) | low;
  endfunction

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no end of run, expected completion");
    report();
  end

  initial begin
    longint unsigned a4, a2, p;
    for (int i = 0; i < NS; i++) for (int j = 0; j < NW; j++) begin
      m_v[i][j] = 0; m_sz[i][j] = 0; m_vpn[i][j] = 0; m_pfn[i][j] = 0;
    end
    for (int i = 0; i < NS; i++) for (int j = 0; j < NW - 1; j++) m_tree[i][j] = 0;

    @(negedge clk);
    repeat (2) begin @(negedge clk); model_step(0, 0, 0, 0); compare("R1"); end
    rst = 1'b0;

    // R1 / R12: empty after reset
    apply(1, 0, 48'h0000_1234_5678, 0, "R1");
    apply(0, 0, 0, 0, "R3");
    apply(1, 0, 48'h4000_0000_0000, 0, "R12");

    // R4: 4 KB translation
    a4 = 48'h0000_1234_5000;
    apply(1, 1, a4, 28'h00ABCDE, "R4");
    apply(1, 0, a4 + 48'h123, 0, "R4");
    apply(1, 0, a4 + 48'hFFF, 0, "R4");
    apply(1, 0, a4 + 48'h1000, 0, "R12");

    // R5: 2 MB translation, low frame bits ignored
    a2 = 48'h4000_1220_0000;
    apply(1, 1, a2, 28'h01234FF, "R5");
    apply(1, 0, a2 + 48'h1F_F0F0, 0, "R5");
    apply(1, 0, a2 + 48'h0_0001, 0, "R5");

    // R2: fault regions
    apply(1, 0, 48'h8000_0000_1000, 0, "R2");
    apply(1, 0, 48'hC000_1234_5000, 0, "R2");

    // R7: one set with two pages of each size
    apply(1, 1, mk(0, 0, 1, 5, 0), 28'h0000111, "R7");
    apply(1, 1, mk(1, 1, 2, 5, 0), 28'h0000200, "R7");
    apply(1, 1, mk(0, 0, 3, 5, 0), 28'h0000333, "R7");
    apply(1, 1, mk(1, 1, 4, 5, 0), 28'h0000400, "R7");
    apply(1, 0, mk(0, 0, 1, 5, 12'h10), 0, "R7");
    apply(1, 0, mk(1, 1, 2, 5, 21'h1ABCD), 0, "R7");
    apply(1, 0, mk(0, 0, 3, 5, 12'h20), 0, "R7");
    apply(1, 0, mk(1, 1, 4, 5, 21'h00001), 0, "R7");

    // R8: replacement in a full mixed set
    apply(1, 0, mk(0, 0, 1, 5, 0), 0, "R8");
    apply(1, 1, mk(0, 0, 9, 5, 0), 28'h0000999, "R8");
    apply(1, 1, mk(1, 1, 8, 5, 0), 28'h0000800, "R8");
    for (int t = 1; t <= 9; t++) begin
      apply(1, 0, mk(0, 0, t, 5, 0), 0, "R8");
      apply(1, 0, mk(1, 1, t, 5, 0), 0, "R8");
    end
    apply(1, 1, mk(0, 0, 9, 5, 0), 28'h0000AAA, "R8");
    apply(1, 0, mk(0, 0, 9, 5, 12'h44), 0, "R8");

    // R6: same index bits, different tag; size-specific index
    apply(1, 0, mk(0, 0, 9 + 16, 5, 0), 0, "R6");
    apply(1, 1, mk(0, 0, 7, 2, 0), 28'h0000777, "R6");
    apply(1, 0, mk(0, 0, 7, 2, 0), 0, "R6");
    apply(1, 0, mk(0, 0, 7, 3, 0), 0, "R6");

    // R11: fault-region fills and invalidates into a full set
    for (int t = 1; t <= 4; t++) apply(1, 1, mk(0, 0, t + 40, 3, 0), 28'(t), "R11");
    for (int t = 1; t <= 6; t++) apply(1, 1, mk(2 + (t & 1), 0, t + 40, 3, 0), 28'hFFF, "R11");
    apply(1, 2, mk(2, 0, 41, 3, 0), 0, "R11");
    for (int t = 1; t <= 4; t++) apply(1, 0, mk(0, 0, t + 40, 3, 0), 0, "R11");

    // R9: invalidate one page only
    apply(1, 2, mk(0, 0, 42, 3, 0), 0, "R9");
    apply(1, 0, mk(0, 0, 42, 3, 0), 0, "R9");
    apply(1, 0, mk(0, 0, 41, 3, 0), 0, "R9");
    apply(1, 0, mk(0, 0, 43, 3, 0), 0, "R9");
    apply(1, 2, a2 + 48'h5555, 0, "R9");
    apply(1, 0, a2, 0, "R9");
    apply(1, 0, a4, 0, "R9");

    // R6 / R8 / R9: randomized mix over a small address pool
    for (int n = 0; n < 3000; n++) begin
      int op, rg, sz;
      longint unsigned va;
      op = ($urandom % 10 < 5) ? 0 : (($urandom % 4 == 0) ? 2 : 1);
      if ($urandom % 60 == 0) op = 3;
      rg = $urandom % 4;
      sz = (rg == 1) ? 1 : 0;
      va = mk(rg, sz, longint'($urandom % 6), int'($urandom % 3), longint'($urandom % 4096));
      p  = longint'($urandom) & 28'hFFFFFFF;
      apply($urandom % 8 != 0, op, va, p, "R6");
    end

    // R10: flush everything
    apply(1, 1, a4, 28'h00ABCDE, "R10");
    apply(1, 3, 0, 0, "R10");
    apply(1, 0, a4, 0, "R10");
    apply(1, 0, a2, 0, "R10");
    apply(0, 0, 0, 0, "R3");
    report();
  end
endmodule